// File: doc/BRIEF.md
# Unrolled LFSR Random Byte and CRC16 Engine

This block holds one 16-bit linear feedback shift register on the CRC16 polynomial x^16 + x^15 + x^2 + 1 (0x8005). The same register serves two purposes. It is a pseudo-random byte source, and it is a byte-wide CRC16 calculator. Each operation advances the register by its own number of basic steps, and all of those steps complete in one clock cycle.

One basic step works as follows. It forms `fb = state[15] ^ in_bit` and shifts the state left by one bit. When `fb` is 1, it then XORs 0x8005 into the result. Random steps use `in_bit = 0`.

Software uses the block through simple register strobes:
- Seed the register with two low-byte writes. For a CRC, the usual seed is 0x0000 or 0xFFFF.
- Then either feed message bytes through the high-byte write port, or consume random bytes with read strobes.
- Read the full state back at any time as two bytes.

A 2-bit mode field selects the behaviour:
- 00 is free-running on demand.
- 01 requests one single step and then clears itself.
- 10 is reserved and acts like 00.
- 11 switches random generation off.

Top module: `crc_rng_lfsr`

## Requirements
- R1: After reset the state reads 0x0000 and the mode field reads 00.
- R2: In mode 00 or 10, a `rd_strobe` pulse advances the state by 13 basic steps with `in_bit = 0`. The result is visible on `state_hi`/`state_lo` at the following clock edge. The fresh random byte is `state_lo`.
- R3: A `seed_we` write moves the old low byte into the high byte and places `seed_data` in the low byte. Two writes therefore load a full 16-bit seed, with the first byte ending up as the high byte.
- R4: A `crc_we` write runs 8 basic steps whose `in_bit` values are `crc_data` bit 7 first, down to bit 0. Writes on consecutive cycles are all absorbed with no stall. From seed 0x0000, the ASCII string "123456789" yields 0xFEE8.
- R5: Writing mode 01 causes exactly one basic step on the next edge. The mode field then reads 00 one cycle later.
- R6: In mode 11, `rd_strobe` leaves the state unchanged. Seed writes and CRC writes still take effect.
- R7: `ctrl_we` loads `ctrl_wdata` into the mode field on the next edge.
- R8: Priority, highest first: seed write, CRC write, pending single step, read strobe. A pending single step that is blocked by a seed or CRC write is kept, and it runs on the next free cycle.
- R9: With no write, no read strobe and no pending step, the state holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the mode field |
| ctrl_wdata | input | 2 | New mode value |
| ctrl_q | output | 2 | Current mode field |
| rd_strobe | input | 1 | Consume one random byte (13-step advance) |
| seed_we | input | 1 | Seed byte write strobe |
| seed_data | input | 8 | Seed byte |
| crc_we | input | 1 | CRC byte write strobe |
| crc_data | input | 8 | Message byte for the CRC update |
| state_hi | output | 8 | State bits 15..8 |
| state_lo | output | 8 | State bits 7..0 |

## Verification
Seed, CRC and random-read results appear on the state bytes one edge after the strobe. The bench drives each strobe on a falling edge and compares at the next falling edge, against a bit-serial model stepped by the same amount.

A mode-01 write needs two edges before it resolves. The first edge loads the mode field, and the second performs the step and clears the field. The bench therefore checks the intermediate 01 value and the final 00 value at separate falling edges.

For back-to-back CRC bytes, the bench checks each byte's result at the falling edge where the next byte is being driven.

// File: rtl/crc_rng_lfsr.sv
module crc_rng_lfsr #(
  parameter int          W          = 16,
  parameter logic [15:0] POLY       = 16'h8005,
  parameter int          RAND_STEPS = 13
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ctrl_we,
  input  logic [1:0]     ctrl_wdata,
  output logic [1:0]     ctrl_q,
  input  logic           rd_strobe,
  input  logic           seed_we,
  input  logic [W/2-1:0] seed_data,
  input  logic           crc_we,
  input  logic [W/2-1:0] crc_data,
  output logic [W/2-1:0] state_hi,
  output logic [W/2-1:0] state_lo
);
  localparam int BW = W / 2;
  localparam logic [1:0] M_STEP = 2'b01;
  localparam logic [1:0] M_OFF  = 2'b11;

  logic [W-1:0] st;
  logic [1:0]   mode;

  function automatic logic [W-1:0] step1(input logic [W-1:0] s, input logic b);
    logic fb;
    fb = s[W-1] ^ b;
    step1 = {s[W-2:0], 1'b0} ^ (fb ? POLY[W-1:0] : '0);
  endfunction

  function automatic logic [W-1:0] rand_adv(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = s;
    for (int i = 0; i < RAND_STEPS; i++) t = step1(t, 1'b0);
    return t;
  endfunction

  function automatic logic [W-1:0] crc_adv(input logic [W-1:0] s, input logic [BW-1:0] d);
    logic [W-1:0] t;
    t = s;
    for (int i = BW - 1; i >= 0; i--) t = step1(t, d[i]);
    return t;
  endfunction

  wire step_go = (mode == M_STEP) && !seed_we && !crc_we;
  wire rand_go = rd_strobe && (mode != M_OFF) && (mode != M_STEP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= '0;
      mode <= 2'b00;
    end else begin
      if (seed_we)      st <= {st[BW-1:0], seed_data};
      else if (crc_we)  st <= crc_adv(st, crc_data);
      else if (step_go) st <= step1(st, 1'b0);
      else if (rand_go) st <= rand_adv(st);

      if (ctrl_we)      mode <= ctrl_wdata;
      else if (step_go) mode <= 2'b00;
    end
  end

  assign ctrl_q   = mode;
  assign state_hi = st[W-1:BW];
  assign state_lo = st[BW-1:0];
endmodule

// File: rtl/crc_rng_lfsr_chk.sv
module crc_rng_lfsr_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ctrl_we,
  input logic [1:0]     ctrl_wdata,
  input logic [1:0]     ctrl_q,
  input logic           rd_strobe,
  input logic           seed_we,
  input logic [W/2-1:0] seed_data,
  input logic           crc_we,
  input logic [W/2-1:0] crc_data,
  input logic [W/2-1:0] state_hi,
  input logic [W/2-1:0] state_lo
);
  // R3
  seed_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seed_we |=> (state_lo == $past(seed_data)) && (state_hi == $past(state_lo)));

  // R5
  step_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b01 && !seed_we && !crc_we && !ctrl_we) |=> ctrl_q == 2'b00);

  // R6
  off_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q == 2'b11 && !seed_we && !crc_we) |=> $stable({state_hi, state_lo}));

  // R7
  mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> ctrl_q == $past(ctrl_wdata));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seed_we && !crc_we && !rd_strobe && ctrl_q != 2'b01) |=> $stable({state_hi, state_lo}));
endmodule

bind crc_rng_lfsr crc_rng_lfsr_chk #(.W(W)) u_chk (.*);

// File: tb/crc_rng_lfsr_tb.sv
module crc_rng_lfsr_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [1:0] ctrl_wdata = 2'b00;
  logic [1:0] ctrl_q;
  logic       rd_strobe = 1'b0;
  logic       seed_we = 1'b0;
  logic [7:0] seed_data = 8'h00;
  logic       crc_we = 1'b0;
  logic [7:0] crc_data = 8'h00;
  logic [7:0] state_hi, state_lo;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model;

  always #4 clk = ~clk;

  crc_rng_lfsr u_dut (.*);

  function automatic logic [15:0] m_step(input logic [15:0] s, input logic b);
    logic fb;
    fb = s[15] ^ b;
    s = {s[14:0], 1'b0};
    if (fb) s = s ^ 16'h8005;
    return s;
  endfunction

  function automatic logic [15:0] m_rand(input logic [15:0] s);
    for (int i = 0; i < 13; i++) s = m_step(s, 1'b0);
    return s;
  endfunction

  function automatic logic [15:0] m_crc(input logic [15:0] s, input logic [7:0] d);
    for (int i = 7; i >= 0; i--) s = m_step(s, d[i]);
    return s;
  endfunction

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic idle_inputs();
    ctrl_we = 0; rd_strobe = 0; seed_we = 0; crc_we = 0;
  endtask

  task automatic seed16(input logic [15:0] v);
    @(negedge clk); idle_inputs(); seed_we = 1; seed_data = v[15:8];
    @(negedge clk); seed_data = v[7:0];
    @(negedge clk); idle_inputs();
    model = v;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk); idle_inputs(); ctrl_we = 1; ctrl_wdata = m;
    @(negedge clk); idle_inputs();
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] msg [9];
    logic [15:0] prev;
    msg = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 state", {state_hi, state_lo}, 16'h0000);
    chk("R1 mode", {14'd0, ctrl_q}, 16'h0000);

    // R3: sweep every low-byte seed, checking byte movement
    model = 16'h0000;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); seed_we = 1; seed_data = v[7:0];
      model = {model[7:0], v[7:0]};
      @(negedge clk); seed_we = 0;
      chk("R3 seed", {state_hi, state_lo}, model);
    end

    // R4: known CRC of "123456789" from zero, bytes back to back
    seed16(16'h0000);
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      if (i > 0) chk("R4 crc back-to-back", {state_hi, state_lo}, model);
      crc_we = 1; crc_data = msg[i];
      model = m_crc(model, msg[i]);
    end
    @(negedge clk); crc_we = 0;
    chk("R4 crc 123456789", {state_hi, state_lo}, 16'hFEE8);

    // R4: sweep of all byte values from both usual seeds
    for (int s = 0; s < 2; s++) begin
      seed16(s == 0 ? 16'h0000 : 16'hFFFF);
      for (int v = 0; v < 256; v++) begin
        @(negedge clk);
        if (v > 0) chk("R4 crc sweep", {state_hi, state_lo}, model);
        crc_we = 1; crc_data = v[7:0];
        model = m_crc(model, v[7:0]);
      end
      @(negedge clk); crc_we = 0;
      chk("R4 crc sweep end", {state_hi, state_lo}, model);
    end

    // R2: random reads in mode 00 from several seeds, back to back
    for (int s = 0; s < 4; s++) begin
      seed16(16'h1234 * (s + 1) + 16'd1);
      for (int r = 0; r < 100; r++) begin
        @(negedge clk);
        if (r > 0) chk("R2 random read", {state_hi, state_lo}, model);
        rd_strobe = 1;
        model = m_rand(model);
      end
      @(negedge clk); rd_strobe = 0;
      chk("R2 random last", {state_hi, state_lo}, model);
    end

    // R2: mode 10 behaves as 00
    set_mode(2'b10);
    @(negedge clk); rd_strobe = 1; model = m_rand(model);
    @(negedge clk); rd_strobe = 0;
    chk("R2 mode10 read", {state_hi, state_lo}, model);

    // R9: idle holds state
    repeat (5) @(negedge clk);
    chk("R9 idle hold", {state_hi, state_lo}, model);

    // R5 / R7: single step and auto clear
    seed16(16'hC001);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = 2'b01;
    @(negedge clk); ctrl_we = 0;
    chk("R7 mode load 01", {14'd0, ctrl_q}, 16'h0001);
    chk("R5 no step yet", {state_hi, state_lo}, model);
    model = m_step(model, 1'b0);
    @(negedge clk);
    chk("R5 single step", {state_hi, state_lo}, model);
    chk("R5 auto clear", {14'd0, ctrl_q}, 16'h0000);
    repeat (2) @(negedge clk);
    chk("R5 only one step", {state_hi, state_lo}, model);

    // R8: pending step blocked by CRC write, then runs
    @(negedge clk); ctrl_we = 1; ctrl_wdata = 2'b01;
    @(negedge clk); ctrl_we = 0; crc_we = 1; crc_data = 8'hA5;
    model = m_crc(model, 8'hA5);
    @(negedge clk); crc_we = 0;
    chk("R8 crc over step", {state_hi, state_lo}, model);
    chk("R8 step still pending", {14'd0, ctrl_q}, 16'h0001);
    model = m_step(model, 1'b0);
    @(negedge clk);
    chk("R8 deferred step", {state_hi, state_lo}, model);
    chk("R8 cleared after step", {14'd0, ctrl_q}, 16'h0000);

    // R8: seed beats CRC in same cycle
    prev = model;
    @(negedge clk); seed_we = 1; seed_data = 8'h5A; crc_we = 1; crc_data = 8'hFF;
    @(negedge clk); idle_inputs();
    model = {prev[7:0], 8'h5A};
    chk("R8 seed over crc", {state_hi, state_lo}, model);

    // R8: pending step beats read strobe
    set_mode(2'b01);
    @(negedge clk);
    chk("R8 step pre", {14'd0, ctrl_q}, 16'h0000);
    model = m_step(model, 1'b0);
    chk("R8 step result", {state_hi, state_lo}, model);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = 2'b01;
    @(negedge clk); ctrl_we = 0; rd_strobe = 1;
    model = m_step(model, 1'b0);
    @(negedge clk); rd_strobe = 0;
    chk("R8 step over read", {state_hi, state_lo}, model);

    // R6: mode 11 blocks reads but not seed and CRC
    set_mode(2'b11);
    chk("R7 mode load 11", {14'd0, ctrl_q}, 16'h0003);
    for (int r = 0; r < 4; r++) begin
      @(negedge clk); rd_strobe = 1;
      @(negedge clk); rd_strobe = 0;
      chk("R6 read ignored", {state_hi, state_lo}, model);
    end
    @(negedge clk); seed_we = 1; seed_data = 8'h77;
    @(negedge clk); seed_we = 0;
    model = {model[7:0], 8'h77};
    chk("R6 seed while off", {state_hi, state_lo}, model);
    @(negedge clk); crc_we = 1; crc_data = 8'h3C;
    @(negedge clk); crc_we = 0;
    model = m_crc(model, 8'h3C);
    chk("R6 crc while off", {state_hi, state_lo}, model);

    // R1: reset mid-run
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R1 reset state", {state_hi, state_lo}, 16'h0000);
    chk("R1 reset mode", {14'd0, ctrl_q}, 16'h0000);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule